// File: doc/BRIEF.md
# Level-Zero Instruction Fetch Filter with Miss Bypass

This block is a tiny direct-mapped instruction store that sits between a processor fetch port and the level-one instruction cache. It holds 16 lines of 16 bytes, 256 bytes in all. Most fetches in a tight loop are served from this small array, and the level-one cache is left idle for those fetches. The core presents one fetch address at a time. The block returns one 32-bit instruction word. Each miss is refilled a whole line at a time from the level-one side, and the level-one side answers with a single-beat line response.

A hit/miss predictor keeps one flag per line. The flag records whether the most recent access to that index found its line resident. When a fetch is accepted, the block reads the flag at the index of the previous fetch's sequential successor. If the flag says "miss", the fetch skips the filter probe and sends its line request to the level-one cache in the same cycle. If the flag says "hit", the filter is probed first. A probe that misses costs one extra cycle before the level-one request goes out. Every refill is written into the filter, including refills for bypassed fetches, and every access updates its predictor flag with the real outcome. Hit, bypass and miss pulses allow hit rate and prediction accuracy to be counted outside the block. A flush input empties the filter and sets every predictor flag back to "hit".

Top module: `l0_fetch_filter`

## Requirements
- R1: After reset, no response, no event pulse and no level-one request is active, and `fch_ready` is high.
- R2: The address splits into tag = bits [31:8], line index = bits [7:4] and byte offset = bits [3:0]. The returned word is the 32-bit word of the line at word position bits [3:2], where word k occupies line bits [32k+31:32k].
- R3: When a fetch predicted to hit finds its line resident, `fch_rsp_valid` and `ev_hit` are high in the cycle after acceptance, and no level-one request is made for that fetch.
- R4: When a fetch predicted to hit finds its line absent, `ev_miss` and `l1_req_valid` are high in the cycle after acceptance. The response appears in the cycle in which `l1_rsp_valid` is high.
- R5: When a fetch is predicted to miss, `ev_bypass` and `l1_req_valid` are high in the same cycle as acceptance. The response appears in the cycle in which `l1_rsp_valid` is high.
- R6: The prediction for a fetch is the flag at the index of (previous accepted address + 4), where 1 means hit. Flags reset to 1, and index 0 is used for the first fetch. Each access writes its own index's flag with whether its line was resident.
- R7: Every refill stores the line, valid and tag at the fetch's index, and this includes refills for bypassed fetches.
- R8: While `flush` is high, `fch_ready` is low. After a flush, all lines are invalid and all flags read "hit".
- R9: `l1_req_addr` is the fetch address with bits [3:0] cleared, and `l1_req_valid` is a single-cycle pulse for each request.
- R10: Only one fetch is in flight at a time. `fch_ready` is low from the cycle after acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all lines and set all predictor flags to hit |
| fch_req_valid | input | 1 | Core fetch request |
| fch_addr | input | 32 | Fetch byte address |
| fch_ready | output | 1 | Fetch may be accepted this cycle |
| fch_rsp_valid | output | 1 | Fetch word valid |
| fch_rsp_data | output | 32 | Fetched instruction word |
| l1_req_valid | output | 1 | Line request pulse to level-one cache |
| l1_req_addr | output | 32 | Line-aligned request address |
| l1_rsp_valid | input | 1 | Line refill valid |
| l1_rsp_line | input | 128 | Refill line data |
| ev_hit | output | 1 | Probe hit pulse |
| ev_bypass | output | 1 | Predicted-miss bypass pulse |
| ev_miss | output | 1 | Probe miss pulse |

## Verification
The hardest case to reach is a bypass whose line is in fact resident. It needs a miss on some index, and then a sequential successor that falls in the same line, so that the flag just cleared is read for a fetch whose line is now present. The directed prologue builds this case on purpose: a cold fetch at 0x100, then 0x104 and 0x108. After that, the predictor flag must flip back so that the third fetch hits. Random stimulus mixes sequential runs with jumps over sixteen possible tags per index, along with occasional flushes. This reaches conflict misses and every combination of prediction and residency.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_FILL  = 2'd2
  } lf_state_e;
endpackage

// File: rtl/lf_line_store.sv
module lf_line_store #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 24,
  parameter int LINE_W    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [NUM_LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  always_comb begin
    valid_d = valid_q;
    if (flush)
      valid_d = '0;
    else if (wr_en)
      valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_line;
      end
    end
  end

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_line = data_q[lk_idx];

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R7
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/lf_hit_predictor.sv
module lf_hit_predictor #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             pred_hit,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_hit
);
  logic [NUM_LINES-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (flush)
      flag_d = '1;
    else if (upd_en)
      flag_d[upd_idx] = upd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '1;
    else        flag_q <= flag_d;
  end

  assign pred_hit = flag_q[rd_idx];

  // R8
  flush_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&flag_q));

  // R6
  update_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !flush) |=> (flag_q[$past(upd_idx)] == $past(upd_hit)));
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int IDX_W      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       fch_req_valid,
  input  logic [ADDR_W-1:0]          fch_addr,
  output logic                       fch_ready,
  output logic                       fch_rsp_valid,
  output logic [WORD_W-1:0]          fch_rsp_data,
  output logic                       l1_req_valid,
  output logic [ADDR_W-1:0]          l1_req_addr,
  input  logic                       l1_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]    l1_rsp_line,
  output logic                       ev_hit,
  output logic                       ev_bypass,
  output logic                       ev_miss,
  output logic [IDX_W-1:0]           lk_idx,
  output logic [ADDR_W-IDX_W-$clog2(LINE_BYTES)-1:0] lk_tag,
  input  logic                       lk_hit,
  input  logic [LINE_BYTES*8-1:0]    lk_line,
  output logic [IDX_W-1:0]           pred_idx,
  input  logic                       pred_hit,
  output logic                       upd_en,
  output logic [IDX_W-1:0]           upd_idx,
  output logic                       upd_hit,
  output logic                       wr_en,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [ADDR_W-IDX_W-$clog2(LINE_BYTES)-1:0] wr_tag
);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WSEL_LSB   = $clog2(WORD_BYTES);
  localparam int WSEL_W     = OFF_W - WSEL_LSB;

  lf_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  nidx_q, nidx_d;
  logic [ADDR_W-1:0] cur_addr, seq_addr;
  logic              accept, bypass_now, probing, filling;
  logic [LINE_BYTES*8-1:0] src_line;
  logic [WSEL_W-1:0] wsel;

  assign fch_ready  = (st_q == ST_IDLE) && !flush;
  assign accept     = fch_req_valid && fch_ready;
  assign probing    = (st_q == ST_PROBE);
  assign filling    = (st_q == ST_FILL) && l1_rsp_valid;
  assign cur_addr   = (st_q == ST_IDLE) ? fch_addr : addr_q;
  assign seq_addr   = fch_addr + ADDR_W'(WORD_BYTES);

  assign lk_idx     = cur_addr[OFF_W +: IDX_W];
  assign lk_tag     = cur_addr[ADDR_W-1 -: TAG_W];
  assign pred_idx   = nidx_q;
  assign bypass_now = accept && !pred_hit;

  assign ev_bypass  = bypass_now;
  assign ev_hit     = probing && lk_hit;
  assign ev_miss    = probing && !lk_hit;

  assign l1_req_valid = bypass_now || ev_miss;
  assign l1_req_addr  = {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign upd_en  = bypass_now || probing;
  assign upd_idx = lk_idx;
  assign upd_hit = lk_hit;

  assign wr_en  = filling;
  assign wr_idx = addr_q[OFF_W +: IDX_W];
  assign wr_tag = addr_q[ADDR_W-1 -: TAG_W];

  assign wsel          = addr_q[WSEL_LSB +: WSEL_W];
  assign src_line      = ev_hit ? lk_line : l1_rsp_line;
  assign fch_rsp_valid = ev_hit || filling;
  assign fch_rsp_data  = src_line[wsel*WORD_W +: WORD_W];

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    nidx_d = nidx_q;
    if (accept) begin
      addr_d = fch_addr;
      nidx_d = seq_addr[OFF_W +: IDX_W];
    end
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = pred_hit ? ST_PROBE : ST_FILL;
      ST_PROBE: st_d = lk_hit ? ST_IDLE : ST_FILL;
      ST_FILL:  if (l1_rsp_valid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      nidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q <= addr_d;
        nidx_q <= nidx_d;
      end
    end
  end

  // R3
  hit_no_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> (!l1_req_valid && fch_rsp_valid));

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |=> !l1_req_valid);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_req_valid && fch_ready) |=> !fch_ready);

  // R5
  events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hit, ev_bypass, ev_miss}));

  // R4
  miss_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (!fch_ready && !l1_req_valid));
endmodule

// File: rtl/l0_fetch_filter.sv
module l0_fetch_filter #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    fch_req_valid,
  input  logic [ADDR_W-1:0]       fch_addr,
  output logic                    fch_ready,
  output logic                    fch_rsp_valid,
  output logic [WORD_W-1:0]       fch_rsp_data,
  output logic                    l1_req_valid,
  output logic [ADDR_W-1:0]       l1_req_addr,
  input  logic                    l1_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] l1_rsp_line,
  output logic                    ev_hit,
  output logic                    ev_bypass,
  output logic                    ev_miss
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [IDX_W-1:0] lk_idx, pred_idx, upd_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             lk_hit, pred_hit, upd_en, upd_hit, wr_en;
  logic [LINE_W-1:0] lk_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  lf_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n_s), .flush(flush),
    .fch_req_valid(fch_req_valid), .fch_addr(fch_addr), .fch_ready(fch_ready),
    .fch_rsp_valid(fch_rsp_valid), .fch_rsp_data(fch_rsp_data),
    .l1_req_valid(l1_req_valid), .l1_req_addr(l1_req_addr),
    .l1_rsp_valid(l1_rsp_valid), .l1_rsp_line(l1_rsp_line),
    .ev_hit(ev_hit), .ev_bypass(ev_bypass), .ev_miss(ev_miss),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_line(lk_line),
    .pred_idx(pred_idx), .pred_hit(pred_hit),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_hit(upd_hit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag)
  );

  lf_line_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n_s), .flush(flush),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_line(lk_line),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(l1_rsp_line)
  );

  lf_hit_predictor #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) pred_i (
    .clk(clk), .rst_n(rst_n_s), .flush(flush),
    .rd_idx(pred_idx), .pred_hit(pred_hit),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_hit(upd_hit)
  );
endmodule

// File: tb/l0_fetch_filter_tb.sv
`timescale 1ns/1ps
module l0_fetch_filter_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         fch_req_valid = 1'b0;
  logic [31:0]  fch_addr = '0;
  logic         fch_ready, fch_rsp_valid;
  logic [31:0]  fch_rsp_data;
  logic         l1_req_valid;
  logic [31:0]  l1_req_addr;
  logic         l1_rsp_valid = 1'b0;
  logic [127:0] l1_rsp_line = '0;
  logic         ev_hit, ev_bypass, ev_miss;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          valid_m [16];
  logic [23:0] tag_m   [16];
  bit          flag_m  [16];
  int          nidx_m;

  always #2.5 clk = ~clk;

  l0_fetch_filter dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fch_req_valid(fch_req_valid), .fch_addr(fch_addr), .fch_ready(fch_ready),
    .fch_rsp_valid(fch_rsp_valid), .fch_rsp_data(fch_rsp_data),
    .l1_req_valid(l1_req_valid), .l1_req_addr(l1_req_addr),
    .l1_rsp_valid(l1_rsp_valid), .l1_rsp_line(l1_rsp_line),
    .ev_hit(ev_hit), .ev_bypass(ev_bypass), .ev_miss(ev_miss)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] base);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of(base + 32'(4*w));
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 16; i++) begin
      valid_m[i] = 1'b0;
      flag_m[i]  = 1'b1;
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    check(fch_ready === 1'b0, "R8 ready during flush", 32'(fch_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  task automatic do_fetch(input logic [31:0] a);
    int idx;
    logic [23:0] tg;
    bit pred, res;
    logic [31:0] base, expd, nxt;
    int lat;
    idx  = int'(a[7:4]);
    tg   = a[31:8];
    pred = flag_m[nidx_m];
    res  = valid_m[idx] && (tag_m[idx] == tg);
    base = {a[31:4], 4'h0};
    expd = word_of({a[31:2], 2'b00});

    @(negedge clk);
    fch_req_valid = 1'b1;
    fch_addr = a;
    #1;
    check(fch_ready === 1'b1, "R10 ready when idle", 32'(fch_ready), 32'd1);
    if (!pred) begin
      check(ev_bypass === 1'b1 && l1_req_valid === 1'b1, "R5/R6 bypass in accept cycle",
            32'({ev_bypass, l1_req_valid}), 32'd3);
      check(l1_req_addr === base, "R9 bypass line address", l1_req_addr, base);
    end else begin
      check(ev_bypass === 1'b0 && l1_req_valid === 1'b0, "R6 no bypass when predicted hit",
            32'({ev_bypass, l1_req_valid}), 32'd0);
    end

    @(negedge clk);
    fch_req_valid = 1'b0;
    #1;
    check(fch_ready === 1'b0, "R10 busy after accept", 32'(fch_ready), 32'd0);
    if (pred && res) begin
      check(ev_hit === 1'b1 && fch_rsp_valid === 1'b1 && l1_req_valid === 1'b0,
            "R3 hit one cycle after accept", 32'({ev_hit, fch_rsp_valid, l1_req_valid}), 32'd6);
      check(fch_rsp_data === expd, "R2 R7 hit data", fch_rsp_data, expd);
    end else begin
      if (pred) begin
        check(ev_miss === 1'b1 && l1_req_valid === 1'b1 && fch_rsp_valid === 1'b0,
              "R4 probe miss request", 32'({ev_miss, l1_req_valid, fch_rsp_valid}), 32'd6);
        check(l1_req_addr === base, "R9 miss line address", l1_req_addr, base);
        @(negedge clk);
        #1;
      end
      check(l1_req_valid === 1'b0, "R9 request is one pulse", 32'(l1_req_valid), 32'd0);
      lat = $urandom_range(0, 3);
      repeat (lat) begin
        check(fch_rsp_valid === 1'b0, "R4/R5 no early response", 32'(fch_rsp_valid), 32'd0);
        @(negedge clk);
        #1;
      end
      l1_rsp_valid = 1'b1;
      l1_rsp_line = line_of(base);
      #1;
      check(fch_rsp_valid === 1'b1, "R4/R5 response with refill", 32'(fch_rsp_valid), 32'd1);
      check(fch_rsp_data === expd, "R2 refill word select", fch_rsp_data, expd);
      @(negedge clk);
      l1_rsp_valid = 1'b0;
      valid_m[idx] = 1'b1;
      tag_m[idx] = tg;
    end
    flag_m[idx] = res;
    nxt = a + 32'd4;
    nidx_m = int'(nxt[7:4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    void'($urandom(32'd1234));
    model_flush();
    nidx_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check(fch_ready === 1'b1, "R1 ready after reset", 32'(fch_ready), 32'd1);
    check({fch_rsp_valid, l1_req_valid, ev_hit, ev_bypass, ev_miss} === 5'b0,
          "R1 outputs quiet after reset", 32'({fch_rsp_valid, l1_req_valid, ev_hit, ev_bypass, ev_miss}), 32'd0);

    // Directed: cold miss, resident bypass, then hit
    do_fetch(32'h0000_0100);
    do_fetch(32'h0000_0104);
    do_fetch(32'h0000_0108);
    do_fetch(32'h0000_010C);
    do_fetch(32'h0000_0110);
    do_fetch(32'h0000_0100);
    // conflict on index 0
    do_fetch(32'h0000_1100);
    do_fetch(32'h0000_0100);
    // flush then refetch
    do_flush();
    do_fetch(32'h0000_0100);
    do_fetch(32'h0000_0104);

    // Random mix of loops and jumps
    pc = 32'h0000_0200;
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 59) == 0) do_flush();
      if ($urandom_range(0, 9) < 7) pc = pc + 32'd4;
      else pc = 32'($urandom_range(0, 1023)) << 2;
      do_fetch(pc);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule